// File: doc/BRIEF.md
# Load/Store Ordering Gate

This block sits between the core's load/store pipeline and the cache and external bus. It decides, cycle by cycle, whether the access the core presents may go ahead or has to wait. A store is posted into a single-entry write buffer and drained to the bus in the background. Each access carries two qualifiers: a strict/relaxed ordering mode, and a flag that marks an access to the core's control-register space.

In relaxed mode, a load that hits the cache may complete while an older store is still waiting in the buffer. A load that has to go to the bus, any load in strict mode, and any control-space load all wait until the buffer is empty. As a result, bus traffic to strictly ordered regions follows program order exactly.

A control-space access always behaves as uncached and strict, whatever mode is presented with it. When a relaxed hit passes a buffered store to the same address, the load returns the store's data rather than the stale cache line. At most one bus transaction is in flight at a time. Ordering is only guaranteed for aligned accesses; the block does not check alignment.

Top module: `mem_order_gate`

## Requirements
- R1: After synchronous reset, bus_req, rsp_valid and req_stall are all low while no request is presented.
- R2: An accepted store (req_valid high, req_write high, req_stall low) appears on the next cycle as bus_req=1, bus_we=1 with its address and data. These hold until a cycle with bus_ready high, after which bus_req drops unless something new was launched.
- R3: A store presented while the buffer holds a store stalls. It is accepted in the cycle after the bus takes the buffered store.
- R4: A relaxed (req_precise=0), non-control load with cache_hit=1 is never stalled by a buffered store. It gives rsp_valid=1 on the next cycle with cache_rdata.
- R5: If that relaxed hit has the same address as the buffered store, rsp_data is the buffered store data instead of cache_rdata.
- R6: A load with cache_hit=0 stalls while a store is buffered. Its bus read (bus_req=1, bus_we=0) starts only after the store has been taken by the bus.
- R7: A strict (req_precise=1) load stalls while a store is buffered, whether it hits or misses. A strict hit with an empty buffer is served from the cache on the next cycle.
- R8: A control-space load (req_ctl=1) is strict and uncached. It waits for an empty buffer and always goes to the bus, even when cache_hit=1 and req_precise=0.
- R9: While a bus read is outstanding, every request stalls. In the cycle after bus_ready completes the read, rsp_valid=1 and rsp_data carries the bus_rdata from that cycle.
- R10: While bus_req is high and bus_ready is low, bus_we, bus_addr and bus_wdata stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core presents an access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_precise | input | 1 | 1 = strict ordering, 0 = relaxed |
| req_ctl | input | 1 | Access targets control-register space |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Store data |
| cache_hit | input | 1 | Cache lookup hit for req_addr |
| cache_rdata | input | DW | Cache data for req_addr |
| req_stall | output | 1 | Access not accepted this cycle |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | DW | Load data |
| bus_req | output | 1 | Bus transaction requested |
| bus_we | output | 1 | Bus transaction is a write |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_ready | input | 1 | Bus accepts/completes the transaction |
| bus_rdata | input | DW | Bus read data, valid with bus_ready on a read |

## Verification
The bench targets a relaxed hit that arrives while the buffered store is stalled by the bus. A gate that waits on any pending store would stall here and lose the relaxed mode's benefit. It also drives same-address hits against a buffered store, where a design without forwarding returns stale cache data. Control-space loads are presented with hit set and relaxed mode; a design that trusts the qualifiers would answer them from the cache and get ahead of the store. Back-to-back stores and misses behind a slow bus expose any design that overwrites the buffer or lets a read onto the bus ahead of the write.

// File: rtl/mog_pkg.sv
package mog_pkg;

  // How an access must be handled relative to the write buffer.
  typedef enum logic [1:0] {
    K_STORE     = 2'd0,  // posted into the write buffer
    K_HIT_LOOSE = 2'd1,  // relaxed cache hit, may pass a buffered store
    K_HIT_TIGHT = 2'd2,  // strict cache hit, waits for empty buffer
    K_BUS_LOAD  = 2'd3   // load served by the bus, waits for empty buffer
  } acc_kind_e;

endpackage

// File: rtl/mog_classify.sv
module mog_classify
  import mog_pkg::*;
(
  input  logic      is_write,
  input  logic      is_precise,
  input  logic      is_ctl,
  input  logic      hit,
  output acc_kind_e kind
);

  logic uncached;
  logic strict;

  // Control space forces uncached + strict regardless of the presented mode.
  assign uncached = is_ctl || !hit;
  assign strict   = is_ctl || is_precise;

  always_comb begin
    if (is_write)      kind = K_STORE;
    else if (uncached) kind = K_BUS_LOAD;
    else if (strict)   kind = K_HIT_TIGHT;
    else               kind = K_HIT_LOOSE;
  end

endmodule

// File: rtl/mog_wbuf.sv
module mog_wbuf #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          drain,
  input  logic [AW-1:0] look_addr,
  output logic          full,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          look_match
);

  logic          vld_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (push) begin
      vld_q <= 1'b1;
    end else if (drain) begin
      vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q <= push_addr;
      data_q <= push_data;
    end
  end

  assign full       = vld_q;
  assign head_addr  = addr_q;
  assign head_data  = data_q;
  assign look_match = vld_q && (addr_q == look_addr);

endmodule

// File: rtl/mog_rdchan.sv
module mog_rdchan #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [AW-1:0] launch_addr,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata,
  input  logic          hit_done,
  input  logic [DW-1:0] hit_data,
  output logic          busy,
  output logic [AW-1:0] rd_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  logic          busy_q;
  logic [AW-1:0] addr_q;
  logic          rv_q;
  logic [DW-1:0] rd_q;
  logic          bus_done;

  assign bus_done = busy_q && bus_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
    end else if (launch) begin
      busy_q <= 1'b1;
    end else if (bus_done) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (launch) addr_q <= launch_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q <= 1'b0;
    end else begin
      rv_q <= bus_done || hit_done;
    end
  end

  always_ff @(posedge clk) begin
    if (bus_done)      rd_q <= bus_rdata;
    else if (hit_done) rd_q <= hit_data;
  end

  assign busy      = busy_q;
  assign rd_addr   = addr_q;
  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;

endmodule

// File: rtl/mem_order_gate.sv
module mem_order_gate
  import mog_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_precise,
  input  logic          req_ctl,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          cache_hit,
  input  logic [DW-1:0] cache_rdata,
  output logic          req_stall,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata
);

  acc_kind_e     kind;
  logic          wb_full;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  logic          wb_match;
  logic          rd_busy;
  logic [AW-1:0] rd_addr;
  logic          accept;
  logic          push_st;
  logic          launch_rd;
  logic          hit_done;
  logic [DW-1:0] hit_data;

  mog_classify u_cls (
    .is_write   (req_write),
    .is_precise (req_precise),
    .is_ctl     (req_ctl),
    .hit        (cache_hit),
    .kind       (kind)
  );

  // Stall decision: one bus transaction at a time, single store slot,
  // only relaxed hits may overtake a buffered store.
  always_comb begin
    req_stall = 1'b0;
    if (req_valid) begin
      if (rd_busy) begin
        req_stall = 1'b1;
      end else begin
        unique case (kind)
          K_HIT_LOOSE: req_stall = 1'b0;
          default:     req_stall = wb_full;
        endcase
      end
    end
  end

  assign accept    = req_valid && !req_stall;
  assign push_st   = accept && (kind == K_STORE);
  assign launch_rd = accept && (kind == K_BUS_LOAD);
  assign hit_done  = accept && ((kind == K_HIT_LOOSE) || (kind == K_HIT_TIGHT));
  assign hit_data  = wb_match ? wb_data : cache_rdata;

  mog_wbuf #(.AW(AW), .DW(DW)) u_wb (
    .clk        (clk),
    .rst        (rst),
    .push       (push_st),
    .push_addr  (req_addr),
    .push_data  (req_wdata),
    .drain      (bus_ready),
    .look_addr  (req_addr),
    .full       (wb_full),
    .head_addr  (wb_addr),
    .head_data  (wb_data),
    .look_match (wb_match)
  );

  mog_rdchan #(.AW(AW), .DW(DW)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .launch      (launch_rd),
    .launch_addr (req_addr),
    .bus_ready   (bus_ready),
    .bus_rdata   (bus_rdata),
    .hit_done    (hit_done),
    .hit_data    (hit_data),
    .busy        (rd_busy),
    .rd_addr     (rd_addr),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data)
  );

  // Store and bus read are never outstanding together, so the bus side
  // is a plain select between two register sets.
  assign bus_req   = wb_full || rd_busy;
  assign bus_we    = wb_full;
  assign bus_addr  = wb_full ? wb_addr : rd_addr;
  assign bus_wdata = wb_data;

endmodule

// File: rtl/mog_chk.sv
module mog_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_write,
  input logic          req_precise,
  input logic          req_ctl,
  input logic          cache_hit,
  input logic          req_stall,
  input logic          rsp_valid,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ready
);

  // R3
  st_waits_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_write && bus_req |-> req_stall);

  // R4
  loose_hit_passes_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write && cache_hit && !req_precise && !req_ctl &&
    !(bus_req && !bus_we) |-> !req_stall);

  // R4
  hit_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_stall && !req_write && cache_hit && !req_ctl |=> rsp_valid);

  // R6
  miss_waits_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write && !cache_hit && bus_req |-> req_stall);

  // R7
  strict_waits_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write && req_precise && bus_req && bus_we |-> req_stall);

  // R8
  ctl_to_bus_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_stall && !req_write && req_ctl |=> bus_req && !bus_we);

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ready |=> bus_req && $stable(bus_we) && $stable(bus_addr) &&
    $stable(bus_wdata));

endmodule

bind mem_order_gate mog_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_precise (req_precise),
  .req_ctl     (req_ctl),
  .cache_hit   (cache_hit),
  .req_stall   (req_stall),
  .rsp_valid   (rsp_valid),
  .bus_req     (bus_req),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_ready   (bus_ready)
);

// File: tb/mem_order_gate_tb_top.sv
`timescale 1ns/1ps
module mem_order_gate_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0, req_precise = 1'b0, req_ctl = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          cache_hit = 1'b0;
  logic [DW-1:0] cache_rdata = '0;
  logic          req_stall, rsp_valid, bus_req, bus_we;
  logic [DW-1:0] rsp_data, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic          bus_ready = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic          m_wb_v = 1'b0, m_rd_v = 1'b0, m_rsp_v = 1'b0;
  logic [AW-1:0] m_wb_a = '0, m_rd_a = '0;
  logic [DW-1:0] m_wb_d = '0, m_rsp_d = '0;

  always #2.5 clk = ~clk;

  mem_order_gate #(.AW(AW), .DW(DW)) dut_i (.*);

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic exp_stall();
    if (!req_valid) return 1'b0;
    if (m_rd_v) return 1'b1;
    if (req_write) return m_wb_v;
    if (!req_ctl && cache_hit && !req_precise) return 1'b0;
    return m_wb_v;
  endfunction

  function automatic string stall_tag();
    if (m_rd_v) return "R9";
    if (req_write) return "R3";
    if (req_ctl) return "R8";
    if (req_precise) return "R7";
    if (!cache_hit) return "R6";
    return "R4";
  endfunction

  // check outputs mid-cycle, then advance model across the edge
  task automatic step();
    logic s, to_bus, fwd;
    #1;
    s = exp_stall();
    chk(stall_tag(), "req_stall", 64'(req_stall), 64'(s));
    chk("R2", "bus_req", 64'(bus_req), 64'(m_wb_v | m_rd_v));
    if (m_wb_v | m_rd_v) begin
      chk("R2", "bus_we", 64'(bus_we), 64'(m_wb_v));
      chk("R10", "bus_addr", 64'(bus_addr), 64'(m_wb_v ? m_wb_a : m_rd_a));
      if (m_wb_v) chk("R10", "bus_wdata", 64'(bus_wdata), 64'(m_wb_d));
    end
    chk("R9", "rsp_valid", 64'(rsp_valid), 64'(m_rsp_v));
    if (m_rsp_v) chk("R5", "rsp_data", 64'(rsp_data), 64'(m_rsp_d));
    @(posedge clk);
    to_bus = req_ctl || !cache_hit;
    fwd    = m_wb_v && (m_wb_a == req_addr);
    m_rsp_v = 1'b0;
    if (m_rd_v && bus_ready) begin
      m_rd_v = 1'b0; m_rsp_v = 1'b1; m_rsp_d = bus_rdata;
    end
    if (req_valid && !s && !req_write && !to_bus) begin
      m_rsp_v = 1'b1;
      m_rsp_d = fwd ? m_wb_d : cache_rdata;
    end
    if (m_wb_v && bus_ready) m_wb_v = 1'b0;
    if (req_valid && !s && req_write) begin
      m_wb_v = 1'b1; m_wb_a = req_addr; m_wb_d = req_wdata;
    end
    if (req_valid && !s && !req_write && to_bus) begin
      m_rd_v = 1'b1; m_rd_a = req_addr;
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic v, input logic w, input logic p, input logic c,
                       input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic h, input logic [DW-1:0] cd,
                       input logic br, input logic [DW-1:0] bd);
    req_valid = v; req_write = w; req_precise = p; req_ctl = c;
    req_addr = a; req_wdata = d; cache_hit = h; cache_rdata = cd;
    bus_ready = br; bus_rdata = bd;
    step();
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1", "bus_req", 64'(bus_req), 64'd0);
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1", "req_stall", 64'(req_stall), 64'd0);
    @(negedge clk);

    // R2/R5: store, then relaxed hit same address while bus busy
    drive(1, 1, 0, 0, 32'h10, 32'hAAAA5555, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 32'h10, 0, 1, 32'h11111111, 0, 0);
    // R3: second store stalls until bus takes the first
    drive(1, 1, 0, 0, 32'h14, 32'h0BADF00D, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 32'h14, 32'h0BADF00D, 0, 0, 1, 0);
    drive(1, 1, 0, 0, 32'h14, 32'h0BADF00D, 0, 0, 0, 0);
    // R7: strict hit waits; R8: control-space hit waits then goes to bus
    drive(1, 0, 1, 0, 32'h20, 0, 1, 32'h22222222, 0, 0);
    drive(1, 0, 0, 1, 32'h24, 0, 1, 32'h33333333, 1, 0);
    drive(1, 0, 0, 1, 32'h24, 0, 1, 32'h33333333, 0, 0);
    // R9: requests stall behind the outstanding read
    drive(1, 0, 0, 0, 32'h28, 0, 1, 32'h44444444, 0, 0);
    drive(1, 0, 0, 0, 32'h28, 0, 1, 32'h44444444, 1, 32'hC0FFEE00);
    // R4: relaxed hit to another address while a store is pending
    drive(1, 1, 0, 0, 32'h30, 32'h5A5A5A5A, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 32'h34, 0, 1, 32'h66666666, 0, 0);
    // R6: miss waits, then launches after drain
    drive(1, 0, 0, 0, 32'h38, 0, 0, 0, 1, 0);
    drive(1, 0, 0, 0, 32'h38, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h77777777);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[0] | r[1], r[2] & r[3], r[4] & r[5], r[6] & r[7] & r[8],
            AW'({$urandom_range(0, 3), 2'b00}), $urandom,
            r[9] | r[10], $urandom, r[11], $urandom);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule